// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This block is a 32-bit integer datapath slice that performs arithmetic whose result is clamped to the representable range instead of wrapping. It covers signed add, subtract and doubling, unsigned add and subtract, and clamping of a value to a programmable bit count, signed or unsigned. The clamp can also work on the two 16-bit halves of the word separately. A plain wrapping add is provided as well. It reports signed overflow without clamping.

Each cycle the block takes an opcode, two operands and a saturation width, and registers the result. Whenever any operation clamps, in any lane, it raises a sticky saturation flag. The flag stays set until a clear input is pulsed. Software can therefore run a long sequence of operations and then ask once whether any of them clamped.

Top module: `sat_alu`

## Requirements
- R1: While reset is low, and right after it is released, `result` is 0 and `sat_flag` is 0.
- R2: Opcode 1 (signed add) gives a+b. When both operands have the same sign and the sum's sign differs from a, it gives 0x7FFFFFFF if a is non-negative and 0x80000000 otherwise, and it marks saturation.
- R3: Opcode 2 (signed subtract) gives a−b. When the operands differ in sign and the difference's sign differs from a, it clamps toward a's sign in the same way as R2 and marks saturation.
- R4: Opcode 3 (signed doubling) gives 2·a. When a ≥ 0x40000000 it gives 0x7FFFFFFF, and when a ≤ 0xC0000000 (signed) it gives 0x80000000. Both bounds are inclusive, and both mark saturation.
- R5: Opcode 4 (checked add) always gives the wrapped sum a+b. It marks saturation under the signed-overflow condition of R2.
- R6: Opcode 5 (unsigned add) gives 0xFFFFFFFF and marks saturation on carry out. Otherwise it gives a+b.
- R7: Opcode 6 (unsigned subtract) gives 0 and marks saturation when a < b. Otherwise it gives a−b.
- R8: Opcode 7 clamps signed a to the range −2^(n−1) … 2^(n−1)−1, where n is `sat_width`. A width of 0 or more than 32 acts as 32. A clamp marks saturation.
- R9: Opcode 8 clamps signed a to 0 … 2^n−1, using the same width rule as R8. A negative a gives 0. A clamp marks saturation.
- R10: Opcode 9 sign-extends each 16-bit half of a and clamps it as in R8. The two clamped halves go back into their own positions. A clamp in either half marks saturation.
- R11: Opcode 10 does the same per-half operation as R10, but with the unsigned clamp of R9.
- R12: A marked saturation sets `sat_flag` after the edge, and the flag stays set through later operations that do not saturate. `sat_clear` clears it, and clear wins over a saturation in the same cycle.
- R13: `result` shows the operation presented before the previous rising edge. Opcode 0 and the unused codes 11–15 give 0 and leave `sat_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (see R2–R13) |
| a | input | 32 | First operand, or the value to clamp |
| b | input | 32 | Second operand |
| sat_width | input | 6 | Clamp bit count for opcodes 7–10 |
| sat_clear | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every arithmetic opcode is driven with a pair of operands just inside its limit and a pair just across it. This separates an overflow test on the wrong sign bit, or an off-by-one bound, from a correct one. The exact doubling bounds 0x40000000 and 0xC0000000 are included, as are widths 1, 31, 32 and the out-of-range widths. The per-half modes use words where only one half clamps, so that a lane mix-up or a missing sign extension gives a distinct wrong word. Directed sequences keep the flag set across clean operations, raise a clear in the same cycle as a saturation, and present opcodes with no operation.

// File: rtl/sat_pkg.sv
package sat_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP    = 4'd0,
      OP_SADD   = 4'd1,
      OP_SSUB   = 4'd2,
      OP_SDBL   = 4'd3,
      OP_ADDCHK = 4'd4,
      OP_UADD   = 4'd5,
      OP_USUB   = 4'd6,
      OP_SCLAMP = 4'd7,
      OP_UCLAMP = 4'd8,
      OP_SCLP16 = 4'd9,
      OP_UCLP16 = 4'd10
   } sat_op_e;

endpackage

// File: rtl/sat_addsub.sv
// Saturating add / subtract / doubling on a full word.
module sat_addsub
   import sat_pkg::*;
#(
   parameter int W = 32
) (
   input  sat_op_e        op,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res,
   output logic           sat
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] DBL_HI = {2'b01, {(W-2){1'b0}}};
   localparam logic [W-1:0] DBL_LO = {2'b11, {(W-2){1'b0}}};

   logic [W:0]   sum_c;
   logic [W-1:0] sum, diff, toward_a;
   logic         add_ovf, sub_ovf, dbl_hi, dbl_lo;

   always_comb begin
      sum_c    = {1'b0, a} + {1'b0, b};
      sum      = sum_c[W-1:0];
      diff     = a - b;
      add_ovf  = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      sub_ovf  = (a[W-1] != b[W-1]) && (diff[W-1] != a[W-1]);
      toward_a = a[W-1] ? SMIN : SMAX;
      dbl_hi   = $signed(a) >= $signed(DBL_HI);
      dbl_lo   = $signed(a) <= $signed(DBL_LO);
   end

   always_comb begin
      res = '0;
      sat = 1'b0;
      unique case (op)
         OP_SADD: begin
            res = add_ovf ? toward_a : sum;
            sat = add_ovf;
         end
         OP_SSUB: begin
            res = sub_ovf ? toward_a : diff;
            sat = sub_ovf;
         end
         OP_SDBL: begin
            if (dbl_hi)      res = SMAX;
            else if (dbl_lo) res = SMIN;
            else             res = {a[W-2:0], 1'b0};
            sat = dbl_hi | dbl_lo;
         end
         OP_ADDCHK: begin
            res = sum;
            sat = add_ovf;
         end
         OP_UADD: begin
            res = sum_c[W] ? {W{1'b1}} : sum;
            sat = sum_c[W];
         end
         OP_USUB: begin
            res = (a < b) ? '0 : diff;
            sat = a < b;
         end
         default: begin
            res = '0;
            sat = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/sat_clamp.sv
// Clamp a signed value to a run-time bit count, signed or unsigned range.
module sat_clamp #(
   parameter int IN_W  = 32,
   parameter int MAX_N = 32,
   parameter int N_W   = $clog2(MAX_N) + 1
) (
   input  logic [IN_W-1:0] din,
   input  logic [N_W-1:0]  n,
   input  logic            is_unsigned,
   output logic [IN_W-1:0] dout,
   output logic            sat
);
   localparam int CW = ((MAX_N > IN_W) ? MAX_N : IN_W) + 2;

   if (IN_W < 2) begin : g_bad_in
      $error("sat_clamp: IN_W must be at least 2");
   end
   if (MAX_N < 1) begin : g_bad_n
      $error("sat_clamp: MAX_N must be at least 1");
   end

   logic signed [CW-1:0] v, lim, s_hi, s_lo, u_hi, pick;

   always_comb begin
      v    = CW'($signed(din));
      lim  = $signed(CW'(1) << (n - N_W'(1)));
      s_hi = lim - CW'(1);
      s_lo = -lim;
      u_hi = $signed((CW'(1) << n) - CW'(1));
      pick = v;
      sat  = 1'b0;
      if (is_unsigned) begin
         if (v < 0) begin
            pick = '0;
            sat  = 1'b1;
         end else if (v > u_hi) begin
            pick = u_hi;
            sat  = 1'b1;
         end
      end else begin
         if (v > s_hi) begin
            pick = s_hi;
            sat  = 1'b1;
         end else if (v < s_lo) begin
            pick = s_lo;
            sat  = 1'b1;
         end
      end
      dout = pick[IN_W-1:0];
   end
endmodule

// File: rtl/sat_sticky.sv
// Sticky flag: set by any saturation, cleared only on request (clear wins).
module sat_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (clr) flag <= 1'b0;
      else if (set) flag <= 1'b1;
   end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
   import sat_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANE_W = 16,
   localparam int WID_W = $clog2(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [WID_W-1:0]  sat_width,
   input  logic              sat_clear,
   output logic [DATA_W-1:0] result,
   output logic              sat_flag
);
   localparam int LANES = DATA_W / LANE_W;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("sat_alu: DATA_W must be a multiple of LANE_W");
   end
   if (LANE_W < 2 || DATA_W < 4) begin : g_bad_w
      $error("sat_alu: widths too small");
   end

   sat_op_e           op_e;
   logic [WID_W-1:0]  n_eff;
   logic [DATA_W-1:0] arith_res, word_res, lane_res, next_res;
   logic              arith_sat, word_sat, next_sat;
   logic [LANES-1:0]  lane_sat;

   assign op_e  = sat_op_e'(op);
   assign n_eff = (sat_width == '0 || sat_width > WID_W'(DATA_W))
                  ? WID_W'(DATA_W) : sat_width;

   sat_addsub #(.W(DATA_W)) u_arith (
      .op  (op_e),
      .a   (a),
      .b   (b),
      .res (arith_res),
      .sat (arith_sat)
   );

   sat_clamp #(.IN_W(DATA_W), .MAX_N(DATA_W), .N_W(WID_W)) u_word (
      .din         (a),
      .n           (n_eff),
      .is_unsigned (op_e == OP_UCLAMP),
      .dout        (word_res),
      .sat         (word_sat)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sat_clamp #(.IN_W(LANE_W), .MAX_N(DATA_W), .N_W(WID_W)) u_lane (
         .din         (a[g*LANE_W +: LANE_W]),
         .n           (n_eff),
         .is_unsigned (op_e == OP_UCLP16),
         .dout        (lane_res[g*LANE_W +: LANE_W]),
         .sat         (lane_sat[g])
      );
   end

   always_comb begin
      next_res = '0;
      next_sat = 1'b0;
      case (op_e)
         OP_SADD, OP_SSUB, OP_SDBL, OP_ADDCHK, OP_UADD, OP_USUB: begin
            next_res = arith_res;
            next_sat = arith_sat;
         end
         OP_SCLAMP, OP_UCLAMP: begin
            next_res = word_res;
            next_sat = word_sat;
         end
         OP_SCLP16, OP_UCLP16: begin
            next_res = lane_res;
            next_sat = |lane_sat;
         end
         default: begin
            next_res = '0;
            next_sat = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= next_res;
   end

   sat_sticky u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (next_sat),
      .clr   (sat_clear),
      .flag  (sat_flag)
   );
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk
   import sat_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [3:0]  op,
   input logic [31:0] a,
   input logic [31:0] b,
   input logic        sat_clear,
   input logic [31:0] result,
   input logic        sat_flag
);
   // R12: clear always empties the flag on the next edge
   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sat_clear |=> !sat_flag);

   // R12: without clear the flag never falls
   a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clear) |=> sat_flag);

   // R2: same-sign signed add keeps the sign of a
   a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SADD && a[31] == b[31]) |=> (result[31] == $past(a[31])));

   // R6: unsigned carry clamps to all ones and raises the flag
   a_r6_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_UADD && a > ~b && !sat_clear) |=> (result == 32'hFFFF_FFFF && sat_flag));

   // R7: borrow gives zero
   a_r7_borrow: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_USUB && a < b) |=> (result == 32'd0));

   // R13: idle and unused opcodes give zero and leave the flag alone
   a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ((op == OP_NOP || op > 4'd10) && !sat_clear) |=> (result == 32'd0 && $stable(sat_flag)));
endmodule

bind sat_alu sat_alu_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op        (op),
   .a         (a),
   .b         (b),
   .sat_clear (sat_clear),
   .result    (result),
   .sat_flag  (sat_flag)
);

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] a = '0, b = '0;
   logic [5:0]  sat_width = '0;
   logic        sat_clear = 1'b0;
   logic [31:0] result;
   logic        sat_flag;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sat_alu u0 (
      .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b),
      .sat_width(sat_width), .sat_clear(sat_clear),
      .result(result), .sat_flag(sat_flag)
   );

   // {op, a, b, width, expected result, expected flag}
   localparam int NV = 38;
   localparam logic [106:0] VEC [NV] = '{
      {4'd1, 32'h0000_0005, 32'h0000_0003, 6'd0, 32'h0000_0008, 1'b0}, // R2
      {4'd1, 32'h7FFF_FFFF, 32'h0000_0001, 6'd0, 32'h7FFF_FFFF, 1'b1}, // R2
      {4'd1, 32'h8000_0000, 32'hFFFF_FFFF, 6'd0, 32'h8000_0000, 1'b1}, // R2
      {4'd1, 32'h7FFF_FFFF, 32'h8000_0000, 6'd0, 32'hFFFF_FFFF, 1'b0}, // R2
      {4'd2, 32'h8000_0000, 32'h0000_0001, 6'd0, 32'h8000_0000, 1'b1}, // R3
      {4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 6'd0, 32'h7FFF_FFFF, 1'b1}, // R3
      {4'd2, 32'h0000_0005, 32'h0000_0008, 6'd0, 32'hFFFF_FFFD, 1'b0}, // R3
      {4'd2, 32'h0000_0000, 32'h8000_0000, 6'd0, 32'h7FFF_FFFF, 1'b1}, // R3
      {4'd3, 32'h3FFF_FFFF, 32'h0,         6'd0, 32'h7FFF_FFFE, 1'b0}, // R4
      {4'd3, 32'h4000_0000, 32'h0,         6'd0, 32'h7FFF_FFFF, 1'b1}, // R4
      {4'd3, 32'hC000_0000, 32'h0,         6'd0, 32'h8000_0000, 1'b1}, // R4
      {4'd3, 32'hC000_0001, 32'h0,         6'd0, 32'h8000_0002, 1'b0}, // R4
      {4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 6'd0, 32'h8000_0000, 1'b1}, // R5
      {4'd4, 32'h0000_0002, 32'h0000_0003, 6'd0, 32'h0000_0005, 1'b0}, // R5
      {4'd5, 32'hFFFF_FFF0, 32'h0000_0010, 6'd0, 32'hFFFF_FFFF, 1'b1}, // R6
      {4'd5, 32'hFFFF_FFF0, 32'h0000_000F, 6'd0, 32'hFFFF_FFFF, 1'b0}, // R6
      {4'd6, 32'h0000_0005, 32'h0000_0006, 6'd0, 32'h0000_0000, 1'b1}, // R7
      {4'd6, 32'h0000_0006, 32'h0000_0006, 6'd0, 32'h0000_0000, 1'b0}, // R7
      {4'd7, 32'h0000_0080, 32'h0,         6'd8, 32'h0000_007F, 1'b1}, // R8
      {4'd7, 32'hFFFF_FF7F, 32'h0,         6'd8, 32'hFFFF_FF80, 1'b1}, // R8
      {4'd7, 32'hFFFF_FF80, 32'h0,         6'd8, 32'hFFFF_FF80, 1'b0}, // R8
      {4'd7, 32'h0000_0001, 32'h0,         6'd1, 32'h0000_0000, 1'b1}, // R8
      {4'd7, 32'h8000_0000, 32'h0,         6'd0, 32'h8000_0000, 1'b0}, // R8
      {4'd7, 32'h7FFF_FFFF, 32'h0,         6'd31, 32'h3FFF_FFFF, 1'b1}, // R8
      {4'd7, 32'h7FFF_FFFF, 32'h0,         6'd40, 32'h7FFF_FFFF, 1'b0}, // R8
      {4'd8, 32'hFFFF_FFFF, 32'h0,         6'd8, 32'h0000_0000, 1'b1}, // R9
      {4'd8, 32'h0000_0100, 32'h0,         6'd8, 32'h0000_00FF, 1'b1}, // R9
      {4'd8, 32'h0000_00FF, 32'h0,         6'd8, 32'h0000_00FF, 1'b0}, // R9
      {4'd8, 32'h8000_0000, 32'h0,         6'd32, 32'h0000_0000, 1'b1}, // R9
      {4'd8, 32'h7FFF_FFFF, 32'h0,         6'd31, 32'h7FFF_FFFF, 1'b0}, // R9
      {4'd9, 32'h0100_FF00, 32'h0,         6'd8, 32'h007F_FF80, 1'b1}, // R10
      {4'd9, 32'h007F_FF80, 32'h0,         6'd8, 32'h007F_FF80, 1'b0}, // R10
      {4'd9, 32'h8000_7FFF, 32'h0,         6'd16, 32'h8000_7FFF, 1'b0}, // R10
      {4'd9, 32'h0005_0200, 32'h0,         6'd4, 32'h0005_0007, 1'b1}, // R10
      {4'd10, 32'hFFFF_0123, 32'h0,        6'd8, 32'h0000_00FF, 1'b1}, // R11
      {4'd10, 32'h0012_0034, 32'h0,        6'd8, 32'h0012_0034, 1'b0}, // R11
      {4'd10, 32'h7FFF_8000, 32'h0,        6'd16, 32'h7FFF_0000, 1'b1}, // R11
      {4'd15, 32'h7FFF_FFFF, 32'h1,        6'd0, 32'h0000_0000, 1'b0}  // R13
   };

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R6";
         4'd6: return "R7";
         4'd7: return "R8";
         4'd8: return "R9";
         4'd9: return "R10";
         4'd10: return "R11";
         default: return "R13";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] got_r, input logic got_f,
                        input logic [31:0] exp_r, input logic exp_f);
      n_run++;
      if (got_r !== exp_r || got_f !== exp_f) begin
         n_fail++;
         $display("FAIL %s: result=%h flag=%b expected result=%h flag=%b",
                  req, got_r, got_f, exp_r, exp_f);
      end
   endtask

   // Present inputs at a falling edge, then move to the next falling edge.
   task automatic step(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                       input logic [5:0] w, input logic clr);
      op = o; a = x; b = y; sat_width = w; sat_clear = clr;
      @(negedge clk);
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1", result, sat_flag, 32'h0, 1'b0);       // R1 during reset
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", result, sat_flag, 32'h0, 1'b0);       // R1 after release

      for (int i = 0; i < NV; i++) begin
         logic [106:0] v;
         v = VEC[i];
         step(4'd0, 32'h0, 32'h0, 6'd0, 1'b1);
         step(v[106:103], v[102:71], v[70:39], v[38:33], 1'b0);
         check(req_of(v[106:103]), result, sat_flag, v[32:1], v[0]);
      end

      // R12: flag survives clean operations
      step(4'd0, 32'h0, 32'h0, 6'd0, 1'b1);
      step(4'd1, 32'h7FFF_FFFF, 32'h1, 6'd0, 1'b0);
      step(4'd1, 32'h1, 32'h2, 6'd0, 1'b0);
      check("R12", result, sat_flag, 32'h3, 1'b1);
      step(4'd8, 32'h5, 32'h0, 6'd8, 1'b0);
      check("R12", result, sat_flag, 32'h5, 1'b1);
      // R13: idle opcode gives zero, keeps flag set
      step(4'd0, 32'h1234_5678, 32'h1, 6'd0, 1'b0);
      check("R13", result, sat_flag, 32'h0, 1'b1);
      step(4'd12, 32'hFFFF_FFFF, 32'h1, 6'd0, 1'b0);
      check("R13", result, sat_flag, 32'h0, 1'b1);
      // R12: clear wins over a saturation in the same cycle
      step(4'd5, 32'hFFFF_FFFF, 32'h1, 6'd0, 1'b1);
      check("R12", result, sat_flag, 32'hFFFF_FFFF, 1'b0);
      // R13: idle opcode keeps a clear flag clear
      step(4'd0, 32'h0, 32'h0, 6'd0, 1'b0);
      check("R13", result, sat_flag, 32'h0, 1'b0);
      // R13: one-cycle latency - result holds until the next rising edge
      op = 4'd1; a = 32'h10; b = 32'h20; sat_width = 6'd0; sat_clear = 1'b0;
      @(posedge clk);
      #1;
      check("R13", result, sat_flag, 32'h30, 1'b0);
      @(negedge clk);
      op = 4'd2; a = 32'h10; b = 32'h1;
      #1;
      check("R13", result, sat_flag, 32'h30, 1'b0);
      @(negedge clk);
      check("R13", result, sat_flag, 32'hF, 1'b0);
      // R1: reset clears a set flag and result
      step(4'd3, 32'h4000_0000, 32'h0, 6'd0, 1'b0);
      check("R4", result, sat_flag, 32'h7FFF_FFFF, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R1", result, sat_flag, 32'h0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      step(4'd0, 32'h0, 32'h0, 6'd0, 1'b0);
      check("R1", result, sat_flag, 32'h0, 1'b0);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule